// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the host-facing register file of a multi-channel event timer. It answers 32-bit accesses in a 1 KB window. It holds the read-only capability word, the global configuration bits and the 64-bit main counter, and it shows the channel status bits on a read. The main counter counts one step per clock while the timer is globally enabled. It holds its value while the timer is disabled, and in that state software may load it one 32-bit half at a time.

The block does not hold channel state. An access that falls in a channel bank is decoded into a channel index and a register select. A write reaches the channel logic as a valid/ready strobe, and a read returns the word the channel logic presents on `ch_rdata`. Changes of the global enable are sent to the channels as single-cycle arm and disarm pulses. On an arm pulse, each channel re-arms itself if its comparator is not all-ones. Status write-1-to-clear requests go out as a one-cycle clear vector. The live counter value is driven to the channels on every clock.

Back-pressure works as follows. A host request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a channel write is being presented and the channel side holds `ch_wr_ready` low. While stalled, the host must hold the request steady. Reads are never stalled. A read answers with `rsp_valid` high for exactly one cycle, on the clock after it is accepted.

Top module: `evt_regfile`

## Requirements
- R1: The capability low word at offset 0x000 reads as: bits 7:0 revision (0x01), bits 12:8 the effective channel count minus one, bit 13 = 1 (64-bit counter), bit 14 = 0, bit 15 = 1 (legacy routing supported), and bits 31:16 the vendor code (0xA5C3). The capability high word at 0x004 reads the tick period in femtoseconds (10,000,000 by default). Writes to either word are ignored. The effective channel count is the channel-count parameter clamped to the range 3 to 32.
- R2: The global config word at 0x010 has two writable bits: bit 0 is the global enable and bit 1 is legacy routing. Its other bits read 0. The word at 0x014 reads 0 and ignores writes. Both bits are also driven on `cfg_enable` and `cfg_legacy`.
- R3: While enabled, `main_count` rises by exactly one on every clock, with the carry passing from bit 31 into bit 32. A read of 0x0F0 (low half) or 0x0F4 (high half) returns the counter value in the cycle the read is accepted.
- R4: While disabled, the counter holds its value, and writes to 0x0F0 and 0x0F4 load only the addressed half. While enabled, writes to either half are ignored.
- R5: A config write that takes the enable from 0 to 1 gives one `arm_pulse` cycle, in the cycle after the write is accepted. A write that takes it from 1 to 0 gives one `disarm_pulse` cycle, also in the cycle after the write. A write that leaves the enable unchanged gives no pulse.
- R6: A read of 0x020 returns `ch_status`, with the bits at or above the effective channel count forced to 0. A write to 0x020 drives `status_clr` = write data under the same mask, for the one cycle after the write is accepted. `status_clr` is 0 at all other times.
- R7: In offsets 0x100 to 0x3FF, the channel index is address bits 9:5 minus 8, and the select is address bits 4:2 (0 config, 1 capability high, 2/3 comparator low/high, 4/5 route low/high). A write with select 0, 2, 3, 4 or 5 to an implemented channel raises `ch_wr_valid`, with the index, select and data on `ch_idx`, `ch_sel` and `ch_wdata`. A read with select 0 to 5 returns `ch_rdata`.
- R8: Accesses to a channel index at or beyond the effective count, accesses with select 6 or 7, writes to a channel's capability high word, and accesses to any unmapped offset have no effect. Reads of these read 0 (except the capability high word of an implemented channel, which reads as in R7). None of these writes raises `ch_wr_valid`.
- R9: `req_ready` is low exactly while a channel write is presented and `ch_wr_ready` is low. Every accepted read gives `rsp_valid` for one cycle on the following clock, with the read data on `rsp_rdata`.
- R10: After reset, the counter is 0, both config bits are 0, and `rsp_valid`, `arm_pulse`, `disarm_pulse` and `status_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the 1 KB window (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_rdata | output | 32 | Read response data |
| ch_wr_valid | output | 1 | Channel register write strobe |
| ch_wr_ready | input | 1 | Channel side accepts the write |
| ch_idx | output | 5 | Channel index decoded from the address |
| ch_sel | output | 3 | Register select within the channel bank |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32 | Channel read data for the presented index and select |
| ch_status | input | 32 | Per-channel interrupt status bits |
| status_clr | output | 32 | One-cycle write-1-to-clear vector for the status bits |
| main_count | output | 64 | Live main counter |
| cfg_enable | output | 1 | Global enable bit |
| cfg_legacy | output | 1 | Legacy routing bit |
| arm_pulse | output | 1 | One-cycle pulse on an enable rise |
| disarm_pulse | output | 1 | One-cycle pulse on an enable fall |

## Verification
Two functions can act in the same clock. The counter steps while a host read of one of its halves is accepted, and it steps while the enable write that stops it is accepted. Both are provoked by reading the low half while the count is near the 32-bit carry and by writing the config word while counting. They are judged against a bench model that advances one step per enabled clock and returns the pre-edge value for reads. A channel write held off by `ch_wr_ready` while the counter runs is also checked: it must keep `req_ready` low and leave the counter stepping without any gap.

// File: rtl/ev_regs_pkg.sv
package ev_regs_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_CAPLO,
    K_CAPHI,
    K_CFG,
    K_CFGHI,
    K_STAT,
    K_CNTLO,
    K_CNTHI,
    K_CHAN,
    K_CHCAP
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [4:0] idx;
    logic [2:0] sel;
  } dec_t;

  // word offsets (byte address >> 2) of the global registers
  localparam logic [5:0] W_CAPLO = 6'h00;
  localparam logic [5:0] W_CAPHI = 6'h01;
  localparam logic [5:0] W_CFG   = 6'h04;
  localparam logic [5:0] W_CFGHI = 6'h05;
  localparam logic [5:0] W_STAT  = 6'h08;
  localparam logic [5:0] W_CNTLO = 6'h3C;
  localparam logic [5:0] W_CNTHI = 6'h3D;

  function automatic int clamp_ch(input int n);
    if (n < 3) return 3;
    if (n > 32) return 32;
    return n;
  endfunction

endpackage

// File: rtl/ev_addr_decode.sv
module ev_addr_decode
  import ev_regs_pkg::*;
#(
  parameter int NCH_EFF = 3
) (
  input  logic [9:0] addr,
  output dec_t       dec
);
  logic [4:0] bank_idx;
  logic       in_range;

  assign bank_idx = addr[9:5] - 5'd8;
  assign in_range = ({1'b0, bank_idx} < 6'(NCH_EFF));

  always_comb begin
    dec.kind = K_NONE;
    dec.idx  = bank_idx;
    dec.sel  = addr[4:2];
    if (addr[9:8] != 2'b00) begin
      if (in_range) begin
        unique case (addr[4:2])
          3'd1:       dec.kind = K_CHCAP;
          3'd6, 3'd7: dec.kind = K_NONE;
          default:    dec.kind = K_CHAN;
        endcase
      end
    end else begin
      unique case (addr[7:2])
        W_CAPLO: dec.kind = K_CAPLO;
        W_CAPHI: dec.kind = K_CAPHI;
        W_CFG:   dec.kind = K_CFG;
        W_CFGHI: dec.kind = K_CFGHI;
        W_STAT:  dec.kind = K_STAT;
        W_CNTLO: dec.kind = K_CNTLO;
        W_CNTHI: dec.kind = K_CNTHI;
        default: dec.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ev_main_counter.sv
module ev_main_counter #(
  parameter int HALF = 32,
  localparam int W = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wdata,
  output logic [W-1:0]    count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (en) begin
      count <= count + 1'b1;
    end else if (wr_lo) begin
      count[HALF-1:0] <= wdata;
    end else if (wr_hi) begin
      count[W-1:HALF] <= wdata;
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (count == $past(count) + 1'b1));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_lo && !wr_hi) |=> $stable(count));

  assert_half_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && wr_lo) |=> (count[W-1:HALF] == $past(count[W-1:HALF])));
endmodule

// File: rtl/ev_global_cfg.sv
module ev_global_cfg (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        enable,
  output logic        legacy,
  output logic        arm,
  output logic        disarm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      legacy <= 1'b0;
      arm    <= 1'b0;
      disarm <= 1'b0;
    end else begin
      arm    <= wr && !enable && wdata[0];
      disarm <= wr && enable && !wdata[0];
      if (wr) begin
        enable <= wdata[0];
        legacy <= wdata[1];
      end
    end
  end

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(arm && disarm));

  assert_arm_rise_R5: assert property (@(posedge clk) disable iff (rst)
    arm |-> (enable && !$past(enable)));

  assert_disarm_fall_R5: assert property (@(posedge clk) disable iff (rst)
    disarm |-> (!enable && $past(enable)));
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import ev_regs_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter logic [7:0]  REV      = 8'h01,
  parameter logic [15:0] VENDOR   = 16'hA5C3,
  parameter logic [31:0] TICK_FS  = 32'd10_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [9:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        ch_wr_valid,
  input  logic        ch_wr_ready,
  output logic [4:0]  ch_idx,
  output logic [2:0]  ch_sel,
  output logic [31:0] ch_wdata,
  input  logic [31:0] ch_rdata,
  input  logic [31:0] ch_status,
  output logic [31:0] status_clr,
  output logic [63:0] main_count,
  output logic        cfg_enable,
  output logic        cfg_legacy,
  output logic        arm_pulse,
  output logic        disarm_pulse
);
  localparam int NCH_EFF = clamp_ch(NUM_CH);
  localparam logic [4:0]  NCH_M1 = 5'(NCH_EFF - 1);
  localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1, NCH_M1, REV};

  dec_t        dec;
  logic        acc, wr_acc, rd_acc;
  logic [31:0] ch_mask;
  logic [31:0] rmux;

  genvar g;
  generate
    for (g = 0; g < 32; g++) begin : g_mask
      if (g < NCH_EFF) begin : g_on
        assign ch_mask[g] = 1'b1;
      end else begin : g_off
        assign ch_mask[g] = 1'b0;
      end
    end
  endgenerate

  ev_addr_decode #(.NCH_EFF(NCH_EFF)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  assign ch_wr_valid = req_valid && req_write && (dec.kind == K_CHAN);
  assign ch_idx      = dec.idx;
  assign ch_sel      = dec.sel;
  assign ch_wdata    = req_wdata;
  assign req_ready   = !(ch_wr_valid && !ch_wr_ready);
  assign acc         = req_valid && req_ready;
  assign wr_acc      = acc && req_write;
  assign rd_acc      = acc && !req_write;

  ev_global_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_acc && (dec.kind == K_CFG)),
    .wdata  (req_wdata),
    .enable (cfg_enable),
    .legacy (cfg_legacy),
    .arm    (arm_pulse),
    .disarm (disarm_pulse)
  );

  ev_main_counter #(.HALF(32)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (cfg_enable),
    .wr_lo (wr_acc && !cfg_enable && (dec.kind == K_CNTLO)),
    .wr_hi (wr_acc && !cfg_enable && (dec.kind == K_CNTHI)),
    .wdata (req_wdata),
    .count (main_count)
  );

  always_comb begin
    unique case (dec.kind)
      K_CAPLO:         rmux = CAP_LO;
      K_CAPHI:         rmux = TICK_FS;
      K_CFG:           rmux = {30'd0, cfg_legacy, cfg_enable};
      K_STAT:          rmux = ch_status & ch_mask;
      K_CNTLO:         rmux = main_count[31:0];
      K_CNTHI:         rmux = main_count[63:32];
      K_CHAN, K_CHCAP: rmux = ch_rdata;
      default:         rmux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 32'd0;
      status_clr <= 32'd0;
    end else begin
      rsp_valid  <= rd_acc;
      if (rd_acc) rsp_rdata <= rmux;
      status_clr <= (wr_acc && (dec.kind == K_STAT)) ? (req_wdata & ch_mask) : 32'd0;
    end
  end

  assert_rsp_follows_read_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_stall_only_chan_R9: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (req_valid && req_write && !ch_wr_ready));

  assert_strobe_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    ch_wr_valid |-> ({1'b0, ch_idx} < 6'(NCH_EFF) && ch_sel != 3'd1 && ch_sel < 3'd6));

  assert_clr_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (status_clr & ~ch_mask) == 32'd0);
endmodule

// File: tb/evt_regfile_test.sv
module evt_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ch_wr_valid;
  logic        ch_wr_ready = 1'b1;
  logic [4:0]  ch_idx;
  logic [2:0]  ch_sel;
  logic [31:0] ch_wdata;
  logic [31:0] ch_rdata;
  logic [31:0] ch_status = '0;
  logic [31:0] status_clr;
  logic [63:0] main_count;
  logic        cfg_enable, cfg_legacy, arm_pulse, disarm_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // channel side stand-in: data identifies index and select
  assign ch_rdata = 32'hC0DE_0000 | (32'(ch_idx) << 8) | 32'(ch_sel);

  evt_regfile #(.NUM_CH(2)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ch_wr_valid(ch_wr_valid),
    .ch_wr_ready(ch_wr_ready), .ch_idx(ch_idx), .ch_sel(ch_sel),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .ch_status(ch_status),
    .status_clr(status_clr), .main_count(main_count), .cfg_enable(cfg_enable),
    .cfg_legacy(cfg_legacy), .arm_pulse(arm_pulse), .disarm_pulse(disarm_pulse)
  );

  // behavioural reference: 3 effective channels (parameter 2 clamped up)
  localparam logic [31:0] MASK3 = 32'h7;
  logic [63:0] m_cnt;
  logic        m_en, m_leg, m_arm, m_dis;
  logic [31:0] m_clr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_en <= 0; m_leg <= 0; m_arm <= 0; m_dis <= 0; m_clr <= 0;
    end else begin
      m_arm <= 0; m_dis <= 0; m_clr <= 0;
      if (m_en) m_cnt <= m_cnt + 1;
      if (req_valid && req_ready && req_write) begin
        case (req_addr)
          10'h010: begin
            m_arm <= !m_en && req_wdata[0];
            m_dis <= m_en && !req_wdata[0];
            m_en  <= req_wdata[0];
            m_leg <= req_wdata[1];
          end
          10'h0F0: if (!m_en) m_cnt[31:0]  <= req_wdata;
          10'h0F4: if (!m_en) m_cnt[63:32] <= req_wdata;
          10'h020: m_clr <= req_wdata & MASK3;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(main_count == m_cnt, "R3 R4 counter", main_count, m_cnt);
      check({cfg_legacy, cfg_enable} == {m_leg, m_en}, "R2 config bits",
            {cfg_legacy, cfg_enable}, {m_leg, m_en});
      check({arm_pulse, disarm_pulse} == {m_arm, m_dis}, "R5 pulses",
            {arm_pulse, disarm_pulse}, {m_arm, m_dis});
      check(status_clr == m_clr, "R6 status clear", status_clr, m_clr);
    end
  end

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d, input bit exp_strobe, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #1;
    check(ch_wr_valid == exp_strobe, tag, ch_wr_valid, exp_strobe);
    if (exp_strobe) begin
      check(ch_idx == 5'(a[9:5] - 5'd8), tag, ch_idx, a[9:5] - 5'd8);
      check(ch_sel == a[4:2], tag, ch_sel, a[4:2]);
      check(ch_wdata == d, tag, ch_wdata, d);
    end
    forever begin
      bit rdy;
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [9:0] a, input logic [31:0] exp_in, input bit use_cnt, input bit hi, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #1;
    exp = use_cnt ? (hi ? m_cnt[63:32] : m_cnt[31:0]) : exp_in;
    check(req_ready == 1'b1, "R9 read never stalled", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R9 rsp_valid", rsp_valid, 1);
    check(rsp_rdata == exp, tag, rsp_rdata, exp);
    #1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 rsp_valid one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    check(main_count == 0, "R10 counter after reset", main_count, 0);
    check({cfg_enable, cfg_legacy} == 0, "R10 cfg after reset", {cfg_enable, cfg_legacy}, 0);
    check({rsp_valid, arm_pulse, disarm_pulse} == 0, "R10 pulses", {rsp_valid, arm_pulse, disarm_pulse}, 0);
    check(status_clr == 0, "R10 status_clr", status_clr, 0);

    // R1 capability words, writes ignored
    bus_read(10'h000, 32'hA5C3_A201, 0, 0, "R1 cap low");
    bus_read(10'h004, 32'd10_000_000, 0, 0, "R1 cap high");
    bus_write(10'h000, 32'h0, 0, "R1 cap write no strobe");
    bus_write(10'h004, 32'h0, 0, "R1 cap write no strobe");
    bus_read(10'h000, 32'hA5C3_A201, 0, 0, "R1 cap low after write");
    bus_read(10'h004, 32'd10_000_000, 0, 0, "R1 cap high after write");

    // R4 load halves while disabled
    bus_write(10'h0F0, 32'hFFFF_FFF0, 0, "R4 write low");
    bus_write(10'h0F4, 32'h0000_0001, 0, "R4 write high");
    bus_read(10'h0F0, 0, 1, 0, "R4 read low");
    bus_read(10'h0F4, 0, 1, 1, "R4 read high");

    // R2 config bits and upper word
    bus_write(10'h010, 32'h0000_0002, 0, "R2 legacy only");
    bus_read(10'h010, 32'h2, 0, 0, "R2 cfg read");
    bus_write(10'h014, 32'hFFFF_FFFF, 0, "R2 upper write");
    bus_read(10'h014, 32'h0, 0, 0, "R2 upper read");

    // R5 arm, R3 running count across the 32-bit carry
    bus_write(10'h010, 32'hFFFF_FFFF, 0, "R5 enable");
    bus_read(10'h010, 32'h3, 0, 0, "R2 cfg masked");
    bus_read(10'h0F0, 0, 1, 0, "R3 live low");
    repeat (12) @(negedge clk);
    bus_read(10'h0F4, 0, 1, 1, "R3 live high after carry");
    bus_write(10'h0F0, 32'h0, 0, "R4 write while enabled ignored");
    bus_write(10'h010, 32'h3, 0, "R5 no pulse on same value");

    // R9 stall on a channel write while counting
    ch_wr_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'h108; req_wdata = 32'h1234_5678;
    repeat (2) begin
      #1;
      check(req_ready == 1'b0, "R9 stall", req_ready, 0);
      check(ch_wr_valid == 1'b1, "R9 strobe held", ch_wr_valid, 1);
      @(negedge clk);
    end
    ch_wr_ready = 1;
    #1;
    check(req_ready == 1'b1, "R9 released", req_ready, 1);
    @(negedge clk);
    req_valid = 0; req_write = 0;

    // R5 disarm, counter freezes
    bus_write(10'h010, 32'h0, 0, "R5 disable");
    repeat (4) @(negedge clk);
    bus_read(10'h0F0, 0, 1, 0, "R4 frozen low");

    // R6 status read and clear
    ch_status = 32'hFFFF_FFFF;
    bus_read(10'h020, 32'h7, 0, 0, "R6 status masked");
    bus_write(10'h020, 32'hFF, 0, "R6 clear write");

    // R7 channel banks
    bus_write(10'h148, 32'hDEAD_BEEF, 1, "R7 chan2 cmp low strobe");
    bus_write(10'h114, 32'h0000_00AA, 1, "R7 chan0 route high strobe");
    bus_read(10'h140, 32'hC0DE_0200, 0, 0, "R7 chan2 cfg read");
    bus_read(10'h12C, 32'hC0DE_0103, 0, 0, "R7 chan1 cmp high read");
    bus_read(10'h104, 32'hC0DE_0001, 0, 0, "R7 chan0 cap high read");

    // R8 ignored accesses
    bus_write(10'h104, 32'h1, 0, "R8 cap high write no strobe");
    bus_write(10'h168, 32'h1, 0, "R8 chan3 out of range write");
    bus_read(10'h168, 32'h0, 0, 0, "R8 chan3 out of range read");
    bus_write(10'h118, 32'h1, 0, "R8 select 6 write");
    bus_read(10'h11C, 32'h0, 0, 0, "R8 select 7 read");
    bus_read(10'h00C, 32'h0, 0, 0, "R8 unmapped read");
    bus_write(10'h0E0, 32'hFFFF_FFFF, 0, "R8 unmapped write");
    bus_read(10'h3FC, 32'h0, 0, 0, "R8 top of window");
    bus_read(10'h0F0, 0, 1, 0, "R8 counter untouched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule